// File: doc/BRIEF.md
# SPI Configuration Slave with Command Strobes and Queue Ports

This block is the host-facing serial port of a radio baseband. A host drives SCLK, MOSI and an active-low chip select, and reads MISO. All four wires are oversampled in the core clock domain. Every transaction opens with one header byte. The header selects one of four actions: a 16-bit register write, a 16-bit register read, a data-less command strobe, or a byte stream. The stream pushes into the transmit queue or pops from the receive queue and lasts until chip select rises.

The header works as follows. Bit 7 chooses the memory bank, which this port does not serve. Bit 6 chooses the direction. Bits 5..0 hold the address, sent MSB first. While the header shifts in, the block returns a live 8-bit status byte. It returns the status byte again during every byte written to the transmit queue, so the host can watch flags such as a transmit underflow while it streams. A transaction may end at any bit when chip select rises. A register write commits only after all 16 data bits have arrived.

The serial format is SPI mode 0. The host places MOSI while SCLK is low, and both sides sample on the rising edge. MISO moves after each falling edge. The timing assumes each SCLK phase lasts at least four core clock cycles.

Top module: `spi_cfg_slave`

## Requirements
- R1: A header with bit 7 = 1 (bank access) is ignored. It produces no strobe, no register write, no push and no pop, and any following bits are ignored too.
- R2: A header with bit 7 = 0 and address bits 5..0 below N_STROBES (default 15, so 0x00..0x0E) gives exactly one `strobe_pulse` of one cycle, with `strobe_idx` equal to the address, whatever bit 6 holds. No data phase follows.
- R3: A header with bits 7,6 = 00 and an address from N_STROBES to 0x3D is followed by 16 data bits, MSB first. After the 16th bit, `reg_we` pulses for one cycle with `reg_addr` and `reg_wdata` set.
- R4: A header with bits 7,6 = 01 and an address from N_STROBES to 0x3D returns `reg_rdata` for `reg_addr` on MISO, MSB first, over the next 16 clocks.
- R5: During the header byte, MISO carries `status_in`, MSB first, as captured when chip select falls.
- R6: Header 0x3E (bit 6 = 0) opens a transmit stream. Each complete 8-bit byte is pushed once through `txq_push`/`txq_data`. During each data byte, MISO returns `status_in` as captured at the preceding byte boundary.
- R7: Header 0x7F (address 0x3F, bit 6 = 1) opens a receive stream. Each byte on MISO is the queue head, popped after it is fully shifted. An empty queue gives 0x00 and no pop.
- R8: If chip select rises early, no partial work is committed. A register write with fewer than 16 data bits causes no `reg_we`, and a partial transmit byte causes no push. The next transaction decodes normally.
- R9: MISO is held at 1 while chip select is high. MISO changes only after SCLK falls.
- R10: A header addressing a queue port against its direction (0x7E, or 0x3F with bit 6 = 0) is ignored. It produces no push and no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, held high when deselected |
| status_in | input | 8 | Live status byte returned to the host |
| reg_addr | output | 6 | Register address of the current transaction |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle register write enable |
| reg_rdata | input | 16 | Register read data for `reg_addr` (combinational) |
| strobe_pulse | output | 1 | One-cycle command strobe |
| strobe_idx | output | 6 | Index of the strobe issued |
| txq_push | output | 1 | One-cycle transmit queue push |
| txq_data | output | 8 | Byte pushed to the transmit queue |
| rxq_pop | output | 1 | One-cycle receive queue pop |
| rxq_data | input | 8 | Receive queue head byte |
| rxq_empty | input | 1 | Receive queue is empty |

## Verification
The hardest case is the receive stream running dry while the host keeps clocking. In that case the head must be popped only after it has been fully shifted, the next head must be read only after the pop has taken effect, and the block must then return zero bytes with no further pop. The bench drives this case with a queue model preloaded with two bytes and a three-byte read. It also aborts a register write and a transmit byte in mid-flight, then runs a clean transaction, so the reset path taken when chip select rises is exercised from several phases.

// File: rtl/spi_cfg_pkg.sv
`timescale 1ns/1ps
package spi_cfg_pkg;
  localparam int SYNC_STAGES = 2;
  localparam int HDR_W  = 8;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;
  localparam logic [ADDR_W-1:0] TXQ_PORT = 6'h3E;
  localparam logic [ADDR_W-1:0] RXQ_PORT = 6'h3F;

  typedef enum logic [2:0] {K_NONE, K_STROBE, K_REG_RD, K_REG_WR, K_TXQ, K_RXQ} cmd_kind_t;
  typedef enum logic [2:0] {PH_ADDR, PH_REG, PH_TXQ, PH_RXQ, PH_DONE} phase_t;
  typedef enum logic [1:0] {LD_ZERO, LD_STATUS, LD_REG, LD_RXQ} load_src_t;

  // Header byte: [7] bank select, [6] direction (1 = read), [5:0] address.
  function automatic cmd_kind_t decode_cmd(input logic [HDR_W-1:0] hdr,
                                           input logic [ADDR_W-1:0] n_strobe);
    logic [ADDR_W-1:0] a;
    a = hdr[ADDR_W-1:0];
    if (hdr[7]) return K_NONE;
    if (a < n_strobe) return K_STROBE;
    if (a == TXQ_PORT) return hdr[6] ? K_NONE : K_TXQ;
    if (a == RXQ_PORT) return hdr[6] ? K_RXQ : K_NONE;
    return hdr[6] ? K_REG_RD : K_REG_WR;
  endfunction
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_edge.sv
`timescale 1ns/1ps
module spi_edge #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= INIT;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_cfg_ctrl.sv
`timescale 1ns/1ps
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int N_STROBES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic [HDR_W-1:0]  status_in,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic [HDR_W-1:0]  rxq_data,
  input  logic              rxq_empty,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              strobe,
  output logic [ADDR_W-1:0] strobe_idx,
  output logic              txq_push,
  output logic [HDR_W-1:0]  txq_data,
  output logic              rxq_pop,
  output logic              so
);
  localparam int BIT_CW = $clog2(WORD_W);
  localparam logic [BIT_CW-1:0] LAST_BYTE_BIT = BIT_CW'(HDR_W - 1);
  localparam logic [BIT_CW-1:0] LAST_WORD_BIT = BIT_CW'(WORD_W - 1);

  phase_t            phase;
  load_src_t         ld_src;
  logic              ld_arm, ld_go, wr_mode, rx_held;
  logic [BIT_CW-1:0] bcnt;
  logic [WORD_W-1:0] sh_in, sh_out;

  // Named events shared by the sequencer and the assertions.
  logic [HDR_W-1:0]  byte_now;
  logic [WORD_W-1:0] word_now;
  logic [HDR_W-1:0]  rx_byte;
  cmd_kind_t         kind_now;
  logic              byte_end, word_end;

  assign byte_now = {sh_in[HDR_W-2:0], mosi};
  assign word_now = {sh_in[WORD_W-2:0], mosi};
  assign kind_now = decode_cmd(byte_now, ADDR_W'(N_STROBES));
  assign byte_end = sck_rise && (bcnt == LAST_BYTE_BIT);
  assign word_end = sck_rise && (bcnt == LAST_WORD_BIT);
  assign rx_byte  = rxq_empty ? {HDR_W{1'b0}} : rxq_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ADDR; ld_src <= LD_ZERO; ld_arm <= 1'b0; ld_go <= 1'b0;
      wr_mode <= 1'b0; rx_held <= 1'b0; bcnt <= '0; sh_in <= '0; sh_out <= '0;
      reg_addr <= '0; reg_wdata <= '0; reg_we <= 1'b0; strobe <= 1'b0;
      strobe_idx <= '0; txq_push <= 1'b0; txq_data <= '0; rxq_pop <= 1'b0;
      so <= 1'b1;
    end else begin
      reg_we <= 1'b0; strobe <= 1'b0; txq_push <= 1'b0; rxq_pop <= 1'b0;
      ld_go <= ld_arm; ld_arm <= 1'b0;
      if (!cs_act) begin
        phase <= PH_ADDR; bcnt <= '0; ld_go <= 1'b0; rx_held <= 1'b0; so <= 1'b1;
      end else if (cs_start) begin
        phase <= PH_ADDR; bcnt <= '0;
        so     <= status_in[HDR_W-1];
        sh_out <= {status_in[HDR_W-2:0], {(WORD_W-HDR_W+1){1'b0}}};
      end else begin
        // Loads run two cycles after a byte edge, so a pop has already landed.
        if (ld_go) begin
          unique case (ld_src)
            LD_STATUS: sh_out <= {status_in, {HDR_W{1'b0}}};
            LD_REG:    sh_out <= reg_rdata;
            LD_RXQ:    begin sh_out <= {rx_byte, {HDR_W{1'b0}}}; rx_held <= !rxq_empty; end
            default:   sh_out <= '0;
          endcase
        end
        if (sck_fall) begin
          so     <= sh_out[WORD_W-1];
          sh_out <= {sh_out[WORD_W-2:0], 1'b0};
        end
        if (sck_rise) begin
          sh_in <= word_now;
          bcnt  <= bcnt + 1'b1;
        end
        unique case (phase)
          PH_ADDR: if (byte_end) begin
            bcnt <= '0; reg_addr <= byte_now[ADDR_W-1:0];
            ld_arm <= 1'b1; ld_src <= LD_ZERO; phase <= PH_DONE;
            unique case (kind_now)
              K_STROBE: begin strobe <= 1'b1; strobe_idx <= byte_now[ADDR_W-1:0]; end
              K_REG_RD: begin phase <= PH_REG; wr_mode <= 1'b0; ld_src <= LD_REG; end
              K_REG_WR: begin phase <= PH_REG; wr_mode <= 1'b1; end
              K_TXQ:    begin phase <= PH_TXQ; ld_src <= LD_STATUS; end
              K_RXQ:    begin phase <= PH_RXQ; ld_src <= LD_RXQ; end
              default:  ;
            endcase
          end
          PH_REG: if (word_end) begin
            reg_we <= wr_mode; reg_wdata <= word_now;
            phase <= PH_DONE; ld_arm <= 1'b1; ld_src <= LD_ZERO;
          end
          PH_TXQ: if (byte_end) begin
            bcnt <= '0; txq_push <= 1'b1; txq_data <= byte_now;
            ld_arm <= 1'b1; ld_src <= LD_STATUS;
          end
          PH_RXQ: if (byte_end) begin
            bcnt <= '0; rxq_pop <= rx_held;
            ld_arm <= 1'b1; ld_src <= LD_RXQ;
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a strobe never lasts more than one cycle
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  // R3: a register write only follows a sampled rising SCLK edge
  p_regwe_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(sck_rise));
  // R6: a push only follows a sampled rising SCLK edge
  p_push_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txq_push |-> $past(sck_rise));
  // R7: never pop an empty receive queue
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> !rxq_empty);
  // R8: no register write once the select has been seen deasserted
  p_no_write_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cs_act));
endmodule

// File: rtl/spi_cfg_slave.sv
`timescale 1ns/1ps
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int N_STROBES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [HDR_W-1:0]  status_in,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              strobe_pulse,
  output logic [ADDR_W-1:0] strobe_idx,
  output logic              txq_push,
  output logic [HDR_W-1:0]  txq_data,
  output logic              rxq_pop,
  input  logic [HDR_W-1:0]  rxq_data,
  input  logic              rxq_empty
);
  logic csn_s, sclk_s, mosi_s;
  logic sck_rise, sck_fall, cs_fall, cs_rise_unused;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sclk, spi_mosi}),
    .q({csn_s, sclk_s, mosi_s})
  );

  spi_edge #(.INIT(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sck_rise), .fall(sck_fall)
  );

  spi_edge #(.INIT(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(csn_s), .rise(cs_rise_unused), .fall(cs_fall)
  );

  spi_cfg_ctrl #(.N_STROBES(N_STROBES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_act(~csn_s), .cs_start(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(mosi_s),
    .status_in(status_in), .reg_rdata(reg_rdata),
    .rxq_data(rxq_data), .rxq_empty(rxq_empty),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .strobe(strobe_pulse), .strobe_idx(strobe_idx),
    .txq_push(txq_push), .txq_data(txq_data),
    .rxq_pop(rxq_pop), .so(spi_miso)
  );

  // R9: once deselection has crossed the synchronizer, MISO rests high
  p_miso_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_csn, SYNC_STAGES + 1) |-> spi_miso);
endmodule

// File: tb/tb_spi_cfg_slave.sv
`timescale 1ns/1ps
module tb_spi_cfg_slave;
  localparam int HALF = 8;
  localparam int NV = 10;
  // {header, data}
  localparam logic [23:0] VEC [NV] = '{
    {8'h01, 16'h0000}, {8'h4E, 16'h0000}, {8'h15, 16'hBEEF}, {8'h55, 16'h0000},
    {8'h3D, 16'h1234}, {8'h7D, 16'h0000}, {8'h8A, 16'hFFFF}, {8'h7E, 16'h00C3},
    {8'h3F, 16'h005A}, {8'h0F, 16'h00FF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [7:0] status_in = 8'h00;
  logic [5:0] reg_addr, strobe_idx;
  logic [15:0] reg_wdata, reg_rdata;
  logic reg_we, strobe_pulse, txq_push, rxq_pop, rxq_empty;
  logic [7:0] txq_data, rxq_data;

  always #4 clk = ~clk;

  function automatic logic [15:0] reg_model(input logic [5:0] a);
    return {a, 2'b01, ~a, 2'b10};
  endfunction
  assign reg_rdata = reg_model(reg_addr);

  // 0 none, 1 strobe, 2 read, 3 write, 4 tx stream, 5 rx stream
  function automatic int exp_kind(input logic [7:0] h);
    if (h[7]) return 0;
    case (h[5:0])
      6'h3E:   return h[6] ? 0 : 4;
      6'h3F:   return h[6] ? 5 : 0;
      default: return (h[5:0] <= 6'd14) ? 1 : (h[6] ? 2 : 3);
    endcase
  endfunction

  // receive queue model
  logic [7:0] rxmem [8];
  int rx_wr = 0, rx_rd = 0;
  assign rxq_empty = (rx_wr == rx_rd);
  assign rxq_data  = rxmem[rx_rd % 8];

  int stb_cnt = 0, we_cnt = 0, push_cnt = 0, pop_cnt = 0;
  logic [5:0] stb_last, we_addr;
  logic [15:0] we_data;
  logic [7:0] txlog [16];
  always @(posedge clk) if (rst_n) begin
    if (strobe_pulse) begin stb_cnt++; stb_last = strobe_idx; end
    if (reg_we) begin we_cnt++; we_addr = reg_addr; we_data = reg_wdata; end
    if (txq_push) begin txlog[push_cnt % 16] = txq_data; push_cnt++; end
    if (rxq_pop) begin pop_cnt++; if (!rxq_empty) rx_rd++; end
  end

  spi_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_in(status_in),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .strobe_pulse(strobe_pulse), .strobe_idx(strobe_idx),
    .txq_push(txq_push), .txq_data(txq_data),
    .rxq_pop(rxq_pop), .rxq_data(rxq_data), .rxq_empty(rxq_empty)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n); repeat (n) @(negedge clk); endtask
  task automatic cs_low(); spi_csn = 1'b0; wait_clk(HALF); endtask
  task automatic cs_high(); wait_clk(HALF); spi_csn = 1'b1; wait_clk(3 * HALF); endtask
  task automatic xfer_bits(input int n, input logic [15:0] dout, output logic [15:0] din);
    din = '0;
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = dout[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      din = {din[14:0], spi_miso};
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  initial begin
    wait_clk(200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int p0, q0, w0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // reset state, R9
    check("R9", "miso idle after reset", spi_miso, 1'b1);
    check("R3", "no write after reset", we_cnt, 0);
    check("R2", "no strobe after reset", stb_cnt, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] h;
      logic [15:0] d;
      int k, s0, w1, pp, qq;
      h = VEC[i][23:16]; d = VEC[i][15:0]; k = exp_kind(h);
      status_in = 8'h5A ^ 8'(i * 37);
      s0 = stb_cnt; w1 = we_cnt; pp = push_cnt; qq = pop_cnt;
      cs_low();
      xfer_bits(8, {8'h00, h}, got);
      check("R5", "status during header", got[7:0], status_in);
      if (k == 2 || k == 3) xfer_bits(16, d, got);
      if (k == 0) xfer_bits(8, d, got);
      cs_high();
      check("R9", "miso idle between frames", spi_miso, 1'b1);
      case (k)
        1: begin
          check("R2", "strobe count", stb_cnt, s0 + 1);
          check("R2", "strobe index", stb_last, h[5:0]);
        end
        2: check("R4", "register read data", got, reg_model(h[5:0]));
        3: begin
          check("R3", "write count", we_cnt, w1 + 1);
          check("R3", "write address", we_addr, h[5:0]);
          check("R3", "write data", we_data, d);
        end
        default: begin
          check(h[7] ? "R1" : "R10", "ignored: writes", we_cnt, w1);
          check(h[7] ? "R1" : "R10", "ignored: strobes", stb_cnt, s0);
          check(h[7] ? "R1" : "R10", "ignored: pushes", push_cnt, pp);
          check(h[7] ? "R1" : "R10", "ignored: pops", pop_cnt, qq);
        end
      endcase
    end

    // R6: transmit stream with status on every data byte
    status_in = 8'h81; p0 = push_cnt;
    cs_low();
    xfer_bits(8, 16'h003E, got);
    xfer_bits(8, 16'h0011, got); check("R6", "status on byte 1", got[7:0], 8'h81);
    xfer_bits(8, 16'h0022, got); check("R6", "status on byte 2", got[7:0], 8'h81);
    xfer_bits(8, 16'h0033, got); check("R6", "status on byte 3", got[7:0], 8'h81);
    cs_high();
    check("R6", "push count", push_cnt, p0 + 3);
    check("R6", "pushed byte 1", txlog[p0 % 16], 8'h11);
    check("R6", "pushed byte 3", txlog[(p0 + 2) % 16], 8'h33);

    // R7: receive stream that runs dry
    rxmem[rx_wr % 8] = 8'hA5; rx_wr++;
    rxmem[rx_wr % 8] = 8'h3C; rx_wr++;
    q0 = pop_cnt;
    cs_low();
    xfer_bits(8, 16'h007F, got);
    xfer_bits(8, 16'h0000, got); check("R7", "rx byte 1", got[7:0], 8'hA5);
    xfer_bits(8, 16'h0000, got); check("R7", "rx byte 2", got[7:0], 8'h3C);
    xfer_bits(8, 16'h0000, got); check("R7", "rx empty byte", got[7:0], 8'h00);
    cs_high();
    check("R7", "pop count", pop_cnt, q0 + 2);
    check("R7", "queue drained", rxq_empty, 1'b1);

    // R8: aborted register write, then aborted transmit byte
    w0 = we_cnt; p0 = push_cnt;
    cs_low(); xfer_bits(8, 16'h0020, got); xfer_bits(8, 16'h00AB, got); cs_high();
    check("R8", "partial write not committed", we_cnt, w0);
    cs_low(); xfer_bits(8, 16'h003E, got); xfer_bits(4, 16'h0009, got); cs_high();
    check("R8", "partial byte not pushed", push_cnt, p0);
    cs_low(); xfer_bits(8, 16'h0021, got); xfer_bits(16, 16'hA55A, got); cs_high();
    check("R8", "recovery write count", we_cnt, w0 + 1);
    check("R3", "recovery write data", we_data, 16'hA55A);
    check("R9", "miso idle at end", spi_miso, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule